// File: doc/BRIEF.md
# Interrupt Message Pending-Bit Controller

This block keeps the pending state of the message-signalled interrupt for one DMA channel. The channel raises an event strobe. If the channel's interrupt-disable control is clear, the event becomes a pending message. The block treats the per-vector mask and the function-wide mask differently from that control. Neither mask prevents the pending flag from being set. The masks only hold back delivery. Once both masks read clear, the block raises a request toward the downstream message queue. It keeps that request up until the queue acknowledges that it has posted the message. A posted message counts as issued, so the pending flag drops in the acknowledge cycle.

A pending message that is still masked can be discarded without being sent. This happens when the interrupt-disable control falls from 1 to 0 and no new event arrives in that cycle. A 32-bit status word shows the pending flag in bit 0, and a small read port returns that word.

The control is a three-state machine:
- `ST_IDLE`: nothing is pending.
- `ST_HELD`: a message is pending but is not yet requested.
- `ST_REQ`: a message is pending and its request is raised.

The transitions are:
- ACCEPT: `ST_IDLE` to `ST_HELD`, on a qualified event while a mask is set.
- FAST_ISSUE: `ST_IDLE` to `ST_REQ`, on a qualified event while both masks are clear.
- UNMASK: `ST_HELD` to `ST_REQ`, when both masks are clear.
- DISCARD: `ST_HELD` to `ST_IDLE`, on a disable fall with no event.
- POSTED: `ST_REQ` to `ST_IDLE`, on an acknowledge with no event.
- REARM: `ST_REQ` to `ST_REQ` or `ST_HELD`, on an acknowledge that coincides with a qualified event.

Top module: `msix_pend_ctrl`

## Requirements
- R1: After a synchronous active-low reset, pend_o is 0 and msg_req_o is 0. The stored previous disable value is 1.
- R2: An event with int_dis_i = 1 leaves pend_o at 0 and msg_req_o at 0.
- R3: A qualified event while vec_mask_i or fn_mask_i is 1 sets pend_o on the next cycle, and msg_req_o stays 0 while either mask is 1.
- R4: A qualified event in ST_IDLE with both masks at 0 drives pend_o = 1 and msg_req_o = 1 on the next cycle, with no wait state.
- R5: A pending, unrequested message raises msg_req_o on the cycle after both masks read 0.
- R6: msg_req_o stays 1 until post_ack_i is 1. Without a coincident event, pend_o and msg_req_o are 0 on the cycle after the acknowledge.
- R7: A qualified event in the acknowledge cycle leaves pend_o = 1 on the next cycle. msg_req_o on that cycle is 1 if both masks are 0 and 0 otherwise.
- R8: If int_dis_i falls from 1 to 0 while in ST_HELD and no qualified event arrives in that cycle, pend_o clears on the next cycle and no request is raised.
- R9: Reading address 0 gives pend_o in bit 0 and zero in bits 31:1. Any other address reads 0.
- R10: Further events while a message is pending merge into it, so only one acknowledge is needed to clear pend_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 1 | Interrupt event strobe from the channel |
| int_dis_i | input | 1 | Channel interrupt-disable control |
| vec_mask_i | input | 1 | Per-vector mask |
| fn_mask_i | input | 1 | Function-wide mask |
| post_ack_i | input | 1 | Message posted by the downstream queue |
| msg_req_o | output | 1 | Message request to the queue |
| pend_o | output | 1 | Pending flag |
| rd_addr_i | input | 4 | Read word address |
| rd_data_o | output | 32 | Read data |

## Verification
The directed patterns are chosen so that each one separates two behaviours:
- An event under disable against an event under mask: the first is dropped and the second is kept.
- An unmasked event in idle: this checks that the request comes with no wait state.
- An unmasking while a message is held: this is deferred issue.
- A disable fall while held against a disable fall that coincides with a new event: discard against keep.
- An acknowledge with a coincident event against a plain acknowledge: rearm against clear.
- Repeated events before a single acknowledge: these show that events merge.

A long stretch of random inputs, with acknowledges from a modelled queue, then tests the state machine against a behavioural model on every clock.

// File: rtl/msix_pend_pkg.sv
package msix_pend_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_REQ  = 2'd2
    } pend_state_t;
endpackage

// File: rtl/msix_dis_edge.sv
module msix_dis_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic int_dis_i,
    output logic dis_fall_o
);
    logic dis_q;

    always_ff @(posedge clk) begin
        if (!rst_n) dis_q <= 1'b1;
        else        dis_q <= int_dis_i;
    end

    assign dis_fall_o = dis_q & ~int_dis_i;

    // R1: a reset leaves the stored disable high, so a low disable right after reset is seen as a fall
    p_reset_prev_r1: assert property (@(posedge clk)
        !rst_n |=> (int_dis_i == 1'b0) == dis_fall_o);
endmodule

// File: rtl/msix_pend_fsm.sv
module msix_pend_fsm
    import msix_pend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic int_dis_i,
    input  logic vec_mask_i,
    input  logic fn_mask_i,
    input  logic post_ack_i,
    input  logic dis_fall_i,
    output logic msg_req_o,
    output logic pend_o
);
    pend_state_t state_q, state_d;
    logic gen, unmasked;

    assign gen      = evt_i & ~int_dis_i;
    assign unmasked = ~vec_mask_i & ~fn_mask_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (gen) state_d = unmasked ? ST_REQ : ST_HELD;   // FAST_ISSUE / ACCEPT
            end
            ST_HELD: begin
                if (dis_fall_i && !gen) state_d = ST_IDLE;        // DISCARD
                else if (unmasked)      state_d = ST_REQ;         // UNMASK
            end
            ST_REQ: begin
                if (post_ack_i) begin
                    if (gen) state_d = unmasked ? ST_REQ : ST_HELD; // REARM
                    else     state_d = ST_IDLE;                     // POSTED
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o    = (state_q != ST_IDLE);
        msg_req_o = (state_q == ST_REQ);
    end

    // R6: an outstanding request is held until the acknowledge
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req_o && !post_ack_i) |=> msg_req_o);
    // R6: a plain acknowledge empties the flag
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req_o && post_ack_i && !evt_i) |=> !pend_o);
    // R3: no new request while a mask is set
    p_mask_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_req_o && (vec_mask_i || fn_mask_i)) |=> !msg_req_o);
    // R4: unmasked event in idle requests on the next cycle
    p_fast_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && evt_i && !int_dis_i && !vec_mask_i && !fn_mask_i) |=> msg_req_o);
    // R8: a disable fall discards a held message
    p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !msg_req_o && dis_fall_i && !evt_i) |=> !pend_o);
    // R2: a disabled event never creates a pending flag
    p_dis_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && int_dis_i) |=> !pend_o);
    // R1: reset state
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!pend_o && !msg_req_o));
endmodule

// File: rtl/msix_stat_rd.sv
module msix_stat_rd #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0
) (
    input  logic              pend_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    logic hit;

    assign hit = (rd_addr_i == STAT_A);
    assign rd_data_o[0] = hit & pend_i;

    generate
        if (DATA_W > 1) begin : g_upper
            assign rd_data_o[DATA_W-1:1] = '0;
        end
    endgenerate

    // R9: the upper bits of the read word are zero
    always_comb begin
        p_upper_zero_r9: assert ((rd_data_o >> 1) == '0);
    end
endmodule

// File: rtl/msix_pend_ctrl.sv
module msix_pend_ctrl #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              int_dis_i,
    input  logic              vec_mask_i,
    input  logic              fn_mask_i,
    input  logic              post_ack_i,
    output logic              msg_req_o,
    output logic              pend_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic dis_fall;

    msix_dis_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_dis_i  (int_dis_i),
        .dis_fall_o (dis_fall)
    );

    msix_pend_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .int_dis_i  (int_dis_i),
        .vec_mask_i (vec_mask_i),
        .fn_mask_i  (fn_mask_i),
        .post_ack_i (post_ack_i),
        .dis_fall_i (dis_fall),
        .msg_req_o  (msg_req_o),
        .pend_o     (pend_o)
    );

    msix_stat_rd #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR)
    ) u_stat (
        .pend_i    (pend_o),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: tb/msix_pend_ctrl_tb.sv
module msix_pend_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt = 1'b0, dis = 1'b1, vm = 1'b0, fm = 1'b0, ack = 1'b0;
    logic [3:0] addr = 4'd0;
    logic req, pend;
    logic [31:0] rdata;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0, armed = 1'b0, auto_ack = 1'b0;
    string tag = "R1";
    int m_pend = 0, m_req = 0, m_prev = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    msix_pend_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .int_dis_i(dis),
        .vec_mask_i(vm), .fn_mask_i(fm), .post_ack_i(ack),
        .msg_req_o(req), .pend_o(pend), .rd_addr_i(addr), .rd_data_o(rdata)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        int g, f, u;
        cyc <= cyc + 1;
        armed <= 1'b1;
        if (!rst_n) begin
            m_pend = 0; m_req = 0; m_prev = 1;
        end else begin
            g = (evt && !dis) ? 1 : 0;
            f = (m_prev == 1 && !dis) ? 1 : 0;
            u = (!vm && !fm) ? 1 : 0;
            if (m_req == 1) begin
                if (ack) begin
                    m_pend = g;
                    m_req  = g & u;
                end
            end else if (m_pend == 1) begin
                if (f == 1 && g == 0) m_pend = 0;
                else if (u == 1)      m_req = 1;
            end else if (g == 1) begin
                m_pend = 1;
                m_req  = u;
            end
            m_prev = dis ? 1 : 0;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (armed && !done) begin
            exp_rd = (addr == 4'd0) ? {31'd0, m_pend[0]} : 32'd0;
            n_cmp++;
            if (pend !== m_pend[0] || req !== m_req[0] || rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s cyc %0d: pend=%b req=%b rd=%h expected pend=%0d req=%0d rd=%h",
                         tag, cyc, pend, req, rdata, m_pend, m_req, exp_rd);
            end
        end
    end

    task automatic step(input logic e, input logic d, input logic v, input logic f, input logic a);
        @(negedge clk);
        evt = e; dis = d; vm = v; fm = f; ack = a;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        tag = "R1"; rst_n = 1'b0; @(negedge clk);
        step(0, 1, 0, 0, 0); rst_n = 1'b1;
        tag = "R2"; step(1, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        tag = "R3"; step(1, 0, 1, 0, 0); step(0, 0, 1, 1, 0); step(0, 0, 0, 1, 0);
        tag = "R5"; step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
        tag = "R6"; step(0, 0, 1, 0, 0); step(0, 0, 1, 0, 1); step(0, 0, 0, 0, 0);
        tag = "R4"; step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
        tag = "R7"; step(1, 0, 0, 0, 1); step(1, 0, 1, 0, 1); step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0);
        tag = "R10"; step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
        tag = "R8"; step(1, 0, 1, 1, 0); step(0, 1, 1, 1, 0); step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        step(1, 0, 1, 1, 0); step(0, 1, 1, 1, 0); step(1, 0, 1, 1, 0); step(0, 0, 1, 1, 0);
        step(0, 0, 1, 0, 0); step(0, 1, 1, 0, 0); step(0, 0, 1, 0, 0);
        tag = "R9"; addr = 4'd5; step(1, 0, 1, 0, 0); step(0, 0, 1, 0, 0);
        addr = 4'd0; step(0, 0, 1, 0, 0); step(0, 1, 1, 0, 0); step(0, 0, 1, 0, 0);
        tag = "R1"; rst_n = 1'b0; step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
        rst_n = 1'b1; step(0, 0, 0, 0, 0);
        tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            evt  = ($urandom_range(0, 3) == 0);
            dis  = ($urandom_range(0, 5) == 0);
            vm   = ($urandom_range(0, 3) == 0);
            fm   = ($urandom_range(0, 4) == 0);
            addr = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
            ack  = req && ($urandom_range(0, 2) == 0);
        end
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > MAX_CYC);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, MAX_CYC);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule